// File: doc/BRIEF.md
# FRL Training FFE Level Tracker

This block follows fixed-rate-link training on the display side channel and keeps, for each of four lanes, the transmit feed-forward equalization (FFE) level that the link partner has asked for. Register events arrive as an address and a data byte. They come either from a snooper watching side-channel reads and writes, or from host I2C writes. The block holds the rate / maximum-FFE configuration byte (31h), the test byte (35h) and the clock-ratio bit (20h), and it decodes the training-request bytes at 41h and 42h into per-lane commands.

Each lane has a small state machine. Its states are `LVL0`, `LVL1`, `LVL2` and `LVL3`, and it has three transitions:
- ADVANCE moves to the next state when a lane request of Eh arrives and the lane is below the advertised maximum.
- HOLD keeps the state in every other case, including saturation.
- CLEAR returns to `LVL0`. CLEAR takes priority over ADVANCE. Its causes are a request of Fh on any lane, a change of rate code, or the clear pulse of the register set.

A 2-bit mode input selects where the levels come from:
- Mode 0 takes snooped traffic.
- Mode 1 takes host writes.
- Modes 2 and 3 take host writes for the registers, but drive the lane outputs from an override input.

The bit-level protocol engines are outside the block.

Top module: `frl_ffe_tracker`

## Requirements
- R1: After reset, all lane levels are 0, the rate code is 0 (gbps 0, lanes 0), the test bits are 0 and tmds_ratio is 0.
- R2: A write to 41h carries lane 0 in data bits 3–0 and lane 1 in bits 7–4. A write to 42h carries lane 2 in bits 3–0 and lane 3 in bits 7–4. A nibble of Eh raises only that lane's level by one. Lane i drives ffe_level bits [2i+1:2i].
- R3: The level saturates at the maximum field, which is bits 7–4 of 31h. A field value above 3 acts as 3.
- R4: A nibble of Fh on any lane returns all four lanes to level 0. This takes priority over an Eh in the same write.
- R5: Request nibbles 0h–Dh leave every level unchanged.
- R6: A write to 31h whose rate code (bits 3–0) differs from the stored code returns all levels to 0. A write with the same code only updates the maximum field.
- R7: The stored rate code decodes as follows, as frl_gbps / frl_lanes:
  - code 0: 0/0
  - code 1: 3/3
  - code 2: 6/3
  - code 3: 6/4
  - code 4: 8/4
  - code 5: 10/4
  - code 6: 12/4
  - codes 7–15: 0/0
- R8: In mode 0 only snoop events update the registers and host writes are ignored. In modes 1–3 only host writes update them and snoop events are ignored. If a snoop event and a host write arrive together in mode 0, the snoop event wins.
- R9: In modes 2 and 3, lane i outputs ovr_ffe bits [2i+1:2i]. The tracked levels keep running and reappear on return to mode 0 or 1.
- R10: Writing 35h sets no_ffe from bit 3, deemph_only from bit 2 and preshoot_only from bit 1. While no_ffe is 1, every lane output is 0 and the stored levels are kept.
- R11: A clear pulse zeroes the 20h, 31h and 35h contents and all lane levels. It takes priority over a register event in the same cycle.
- R12: Bit 1 of a write to 20h is stored and driven on tmds_ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Level source select (0 snoop, 1 host, 2/3 override) |
| snp_valid | input | 1 | Snooped register event present |
| snp_addr | input | 8 | Snooped register offset |
| snp_data | input | 8 | Snooped register data |
| host_valid | input | 1 | Host write present |
| host_addr | input | 8 | Host write offset |
| host_data | input | 8 | Host write data |
| scdc_clear | input | 1 | One-cycle clear of the tracked register set |
| ovr_ffe | input | 8 | Per-lane override levels, 2 bits per lane |
| ffe_level | output | 8 | Per-lane FFE level, 2 bits per lane |
| frl_gbps | output | 4 | Decoded per-lane rate in Gbps |
| frl_lanes | output | 3 | Decoded lane count |
| no_ffe | output | 1 | Test bit: FFE disabled |
| deemph_only | output | 1 | Test bit: de-emphasis only |
| preshoot_only | output | 1 | Test bit: pre-shoot only |
| tmds_ratio | output | 1 | Stored clock-ratio bit |

## Verification
An event or clear pulse that is sampled on a rising edge shows on ffe_level, frl_gbps, frl_lanes, the test bits and tmds_ratio right after that same edge, so its results are due one cycle after it is presented. A change of mode or ovr_ffe alters ffe_level within the same cycle. The bench drives inputs 1 ns after each rising edge and updates its behavioural model on the edge. It compares every output with the model at the falling edge, which falls after both kinds of change have settled. Directed checks follow each event at that falling edge, with expected values written from the requirements.

// File: rtl/frl_pkg.sv
`timescale 1ns/1ps
package frl_pkg;
    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } lvl_e;

    localparam logic [3:0] REQ_ADVANCE = 4'hE;
    localparam logic [3:0] REQ_CLEAR   = 4'hF;
    localparam logic [1:0] LVL_CEIL    = 2'd3;
endpackage

// File: rtl/frl_regs.sv
`timescale 1ns/1ps
module frl_regs #(
    parameter int LANES = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [7:0] TMDS_ADDR = 8'h20,
    parameter logic [7:0] CFG_ADDR  = 8'h31,
    parameter logic [7:0] TEST_ADDR = 8'h35,
    parameter logic [7:0] REQ_BASE  = 8'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    input  logic              host_valid,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              scdc_clear,
    output logic [3:0]        rate_code,
    output logic [1:0]        max_lvl,
    output logic [2:0]        test_bits,
    output logic              tmds_bit,
    output logic              rate_chg,
    output logic              clr_all,
    output logic [LANES-1:0]  lane_adv
);
    import frl_pkg::*;

    localparam int NIB = 4;
    localparam int PER_REG = DATA_W / NIB;

    logic              ev_vld;
    logic [ADDR_W-1:0] ev_addr;
    logic [DATA_W-1:0] ev_data;
    logic              hit_cfg, hit_test, hit_tmds;
    logic [LANES-1:0]  is_f;
    logic [3:0]        rate_q;
    logic [3:0]        maxf_q;
    logic [2:0]        test_q;
    logic              tmds_q;

    always_comb begin
        if (mode == 2'd0) begin
            ev_vld  = snp_valid;
            ev_addr = snp_addr;
            ev_data = snp_data;
        end else begin
            ev_vld  = host_valid;
            ev_addr = host_addr;
            ev_data = host_data;
        end
        hit_cfg  = ev_vld && (ev_addr == ADDR_W'(CFG_ADDR));
        hit_test = ev_vld && (ev_addr == ADDR_W'(TEST_ADDR));
        hit_tmds = ev_vld && (ev_addr == ADDR_W'(TMDS_ADDR));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_dec
        localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(REQ_BASE) + ADDR_W'(g / PER_REG);
        logic [NIB-1:0] nib;
        logic           hit;
        assign hit = ev_vld && (ev_addr == LANE_ADDR);
        assign nib = ev_data[NIB*(g % PER_REG) +: NIB];
        assign is_f[g]     = hit && (nib == REQ_CLEAR);
        assign lane_adv[g] = hit && (nib == REQ_ADVANCE);
    end

    assign rate_chg = hit_cfg && !scdc_clear && (ev_data[3:0] != rate_q);
    assign clr_all  = scdc_clear || rate_chg || (|is_f);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= '0;
            maxf_q <= '0;
            test_q <= '0;
            tmds_q <= 1'b0;
        end else if (scdc_clear) begin
            rate_q <= '0;
            maxf_q <= '0;
            test_q <= '0;
            tmds_q <= 1'b0;
        end else begin
            if (hit_cfg) begin
                rate_q <= ev_data[3:0];
                maxf_q <= ev_data[7:4];
            end
            if (hit_test) test_q <= ev_data[3:1];
            if (hit_tmds) tmds_q <= ev_data[1];
        end
    end

    assign rate_code = rate_q;
    assign max_lvl   = (maxf_q > 4'(LVL_CEIL)) ? LVL_CEIL : maxf_q[1:0];
    assign test_bits = test_q;
    assign tmds_bit  = tmds_q;

    // R11: a clear pulse leaves the held registers at zero
    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        scdc_clear |=> (rate_code == 4'd0 && test_bits == 3'd0 && !tmds_bit))
        else $error("assert_clear_zero_R11");

    // R8: without a selected event the rate code stays put
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_vld && !scdc_clear) |=> $stable(rate_code))
        else $error("assert_idle_hold_R8");
endmodule

// File: rtl/ffe_lane.sv
`timescale 1ns/1ps
module ffe_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic [1:0] max_lvl,
    output logic [1:0] lvl
);
    import frl_pkg::*;

    lvl_e st_q, st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LVL0;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            LVL0: if (adv && max_lvl > 2'd0) st_n = LVL1;
            LVL1: if (adv && max_lvl > 2'd1) st_n = LVL2;
            LVL2: if (adv && max_lvl > 2'd2) st_n = LVL3;
            LVL3: st_n = LVL3;
        endcase
        if (clr) st_n = LVL0;
    end

    assign lvl = st_q;

    // R4: a clear always lands on level 0
    assert_clear_lvl0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lvl == 2'd0))
        else $error("assert_clear_lvl0_R4");

    // R2: an advance below the maximum raises by exactly one
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && lvl < max_lvl) |=> (lvl == $past(lvl) + 2'd1))
        else $error("assert_step_one_R2");

    // R3: an advance at or above the maximum holds the level
    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && lvl >= max_lvl) |=> $stable(lvl))
        else $error("assert_saturate_R3");
endmodule

// File: rtl/frl_rate_dec.sv
`timescale 1ns/1ps
module frl_rate_dec #(
    parameter int GBPS_W = 4,
    parameter int CNT_W  = 3
) (
    input  logic [3:0]        code,
    output logic [GBPS_W-1:0] gbps,
    output logic [CNT_W-1:0]  lanes
);
    always_comb begin
        case (code)
            4'd1:    begin gbps = GBPS_W'(3);  lanes = CNT_W'(3); end
            4'd2:    begin gbps = GBPS_W'(6);  lanes = CNT_W'(3); end
            4'd3:    begin gbps = GBPS_W'(6);  lanes = CNT_W'(4); end
            4'd4:    begin gbps = GBPS_W'(8);  lanes = CNT_W'(4); end
            4'd5:    begin gbps = GBPS_W'(10); lanes = CNT_W'(4); end
            4'd6:    begin gbps = GBPS_W'(12); lanes = CNT_W'(4); end
            default: begin gbps = '0;          lanes = '0;        end
        endcase
    end

    // R7: off codes never report a lane count
    always_comb begin
        assert_off_codes_R7: assert ((code != 4'd0 && code < 4'd7) || lanes == '0)
            else $error("assert_off_codes_R7");
    end
endmodule

// File: rtl/frl_ffe_tracker.sv
`timescale 1ns/1ps
module frl_ffe_tracker #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int GBPS_W = 4,
    parameter int CNT_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 snp_valid,
    input  logic [ADDR_W-1:0]    snp_addr,
    input  logic [DATA_W-1:0]    snp_data,
    input  logic                 host_valid,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [DATA_W-1:0]    host_data,
    input  logic                 scdc_clear,
    input  logic [2*LANES-1:0]   ovr_ffe,
    output logic [2*LANES-1:0]   ffe_level,
    output logic [GBPS_W-1:0]    frl_gbps,
    output logic [CNT_W-1:0]     frl_lanes,
    output logic                 no_ffe,
    output logic                 deemph_only,
    output logic                 preshoot_only,
    output logic                 tmds_ratio
);
    logic [3:0]         rate_code;
    logic [1:0]         max_lvl;
    logic [2:0]         test_bits;
    logic               rate_chg;
    logic               clr_all;
    logic [LANES-1:0]   lane_adv;
    logic [2*LANES-1:0] trk_lvl;

    frl_regs #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_data(snp_data),
        .host_valid(host_valid), .host_addr(host_addr), .host_data(host_data),
        .scdc_clear(scdc_clear),
        .rate_code(rate_code), .max_lvl(max_lvl), .test_bits(test_bits),
        .tmds_bit(tmds_ratio), .rate_chg(rate_chg), .clr_all(clr_all),
        .lane_adv(lane_adv)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ffe_lane u_lane (
            .clk(clk), .rst_n(rst_n), .clr(clr_all), .adv(lane_adv[g]),
            .max_lvl(max_lvl), .lvl(trk_lvl[2*g +: 2])
        );
        always_comb begin
            if (no_ffe)        ffe_level[2*g +: 2] = 2'd0;
            else if (mode[1])  ffe_level[2*g +: 2] = ovr_ffe[2*g +: 2];
            else               ffe_level[2*g +: 2] = trk_lvl[2*g +: 2];
        end
    end

    frl_rate_dec #(.GBPS_W(GBPS_W), .CNT_W(CNT_W)) u_dec (
        .code(rate_code), .gbps(frl_gbps), .lanes(frl_lanes)
    );

    assign no_ffe        = test_bits[2];
    assign deemph_only   = test_bits[1];
    assign preshoot_only = test_bits[0];

    // R6: a new rate code empties every lane tracker
    assert_rate_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rate_chg |=> (trk_lvl == '0))
        else $error("assert_rate_reset_R6");
endmodule

// File: tb/frl_ffe_tracker_tb.sv
`timescale 1ns/1ps
module frl_ffe_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       snp_valid = 1'b0, host_valid = 1'b0, scdc_clear = 1'b0;
    logic [7:0] snp_addr = '0, snp_data = '0, host_addr = '0, host_data = '0;
    logic [7:0] ovr_ffe = '0;
    logic [7:0] ffe_level;
    logic [3:0] frl_gbps;
    logic [2:0] frl_lanes;
    logic       no_ffe, deemph_only, preshoot_only, tmds_ratio;

    int total = 0, bad = 0;
    bit started = 0, done = 0;
    string tag = "R1";

    int m_lvl [4];
    int m_max = 0, m_rate = 0, m_test = 0, m_tmds = 0;

    always #2 clk = ~clk;

    frl_ffe_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_data(snp_data),
        .host_valid(host_valid), .host_addr(host_addr), .host_data(host_data),
        .scdc_clear(scdc_clear), .ovr_ffe(ovr_ffe), .ffe_level(ffe_level),
        .frl_gbps(frl_gbps), .frl_lanes(frl_lanes), .no_ffe(no_ffe),
        .deemph_only(deemph_only), .preshoot_only(preshoot_only),
        .tmds_ratio(tmds_ratio)
    );

    function automatic int exp_gbps(int c);
        case (c) 1: return 3; 2: return 6; 3: return 6; 4: return 8;
                 5: return 10; 6: return 12; default: return 0; endcase
    endfunction
    function automatic int exp_lanes(int c);
        if (c >= 1 && c <= 2) return 3;
        if (c >= 3 && c <= 6) return 4;
        return 0;
    endfunction
    function automatic int exp_ffe();
        int v = 0;
        if ((m_test & 8) != 0) return 0;
        for (int i = 0; i < 4; i++)
            v += (mode[1] ? ((ovr_ffe >> (2*i)) & 3) : m_lvl[i]) << (2*i);
        return v;
    endfunction

    // behavioural reference model, updated on each rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n || scdc_clear) begin
            for (int i = 0; i < 4; i++) m_lvl[i] = 0;
            m_max = 0; m_rate = 0; m_test = 0; m_tmds = 0;
        end else begin
            bit v; int a, d;
            v = (mode == 0) ? snp_valid : host_valid;
            a = (mode == 0) ? snp_addr : host_addr;
            d = (mode == 0) ? snp_data : host_data;
            if (v) begin
                if (a == 'h31) begin
                    if ((d & 15) != m_rate) for (int i = 0; i < 4; i++) m_lvl[i] = 0;
                    m_rate = d & 15; m_max = (d >> 4) & 15;
                end else if (a == 'h35) m_test = d & 'h0E;
                else if (a == 'h20) m_tmds = (d >> 1) & 1;
                else if (a == 'h41 || a == 'h42) begin
                    int base, lim; bit anyf;
                    base = (a == 'h41) ? 0 : 2;
                    lim = (m_max > 3) ? 3 : m_max;
                    anyf = ((d & 15) == 15) || (((d >> 4) & 15) == 15);
                    if (anyf) for (int i = 0; i < 4; i++) m_lvl[i] = 0;
                    else for (int k = 0; k < 2; k++)
                        if (((d >> (4*k)) & 15) == 14 && m_lvl[base+k] < lim)
                            m_lvl[base+k]++;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            total++;
            if (int'(ffe_level) != exp_ffe() || int'(frl_gbps) != exp_gbps(m_rate) ||
                int'(frl_lanes) != exp_lanes(m_rate) ||
                int'({no_ffe, deemph_only, preshoot_only, 1'b0}) != m_test ||
                int'(tmds_ratio) != m_tmds) begin
                bad++;
                $display("FAIL %s model: ffe=%h/%h gbps=%0d/%0d lanes=%0d/%0d test=%h/%h tmds=%0d/%0d",
                    tag, ffe_level, exp_ffe(), frl_gbps, exp_gbps(m_rate), frl_lanes,
                    exp_lanes(m_rate), {no_ffe, deemph_only, preshoot_only, 1'b0}, m_test,
                    tmds_ratio, m_tmds);
            end
        end
    end

    task automatic check(string t, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic ev(bit host, logic [7:0] a, logic [7:0] d, bit clr = 0);
        @(posedge clk); #1;
        if (host) begin host_valid = 1; host_addr = a; host_data = d; end
        else begin snp_valid = 1; snp_addr = a; snp_data = d; end
        scdc_clear = clr;
        @(posedge clk); #1;
        host_valid = 0; snp_valid = 0; scdc_clear = 0;
        @(negedge clk);
    endtask

    task automatic set_mode(logic [1:0] m);
        @(posedge clk); #1; mode = m; @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        tag = "R1";
        check("R1 ffe", ffe_level, 0);
        check("R1 gbps/lanes", {frl_gbps, frl_lanes}, 0);
        check("R1 test/tmds", {no_ffe, deemph_only, preshoot_only, tmds_ratio}, 0);

        tag = "R2";
        ev(0, 8'h31, 8'h33);
        check("R7 code3", {frl_gbps, 1'b0, frl_lanes}, {4'd6, 4'd4});
        ev(0, 8'h41, 8'hE0);
        check("R2 lane1 only", ffe_level, 8'h04);
        ev(0, 8'h42, 8'hEE);
        check("R2 lanes2,3", ffe_level, 8'h54);
        tag = "R3";
        repeat (3) ev(0, 8'h41, 8'hEE);
        check("R3 saturate at 3", ffe_level, 8'h5F);
        tag = "R5";
        ev(0, 8'h41, 8'h5D);
        ev(0, 8'h42, 8'h00);
        check("R5 other codes", ffe_level, 8'h5F);
        tag = "R4";
        ev(0, 8'h42, 8'hFE);
        check("R4 Fh clears all", ffe_level, 8'h00);
        tag = "R8";
        ev(1, 8'h41, 8'hEE);
        check("R8 host ignored in mode0", ffe_level, 8'h00);

        tag = "R6";
        ev(0, 8'h41, 8'h0E);
        ev(0, 8'h31, 8'h13);
        check("R6 same rate keeps", ffe_level, 8'h01);
        tag = "R3";
        repeat (2) ev(0, 8'h41, 8'h0E);
        check("R3 saturate at 1", ffe_level, 8'h01);
        ev(0, 8'h42, 8'hE0);
        tag = "R6";
        ev(0, 8'h31, 8'h14);
        check("R6 rate change clears", ffe_level, 8'h00);
        check("R7 code4", {frl_gbps, 1'b0, frl_lanes}, {4'd8, 4'd4});
        tag = "R3";
        ev(0, 8'h31, 8'h94);
        repeat (4) ev(0, 8'h41, 8'hE0);
        check("R3 max field 9 acts as 3", ffe_level, 8'h0C);

        tag = "R7";
        for (int c = 0; c < 16; c++) begin
            ev(0, 8'h31, {4'h3, 4'(c)});
            check("R7 gbps", frl_gbps, exp_gbps(c));
            check("R7 lanes", frl_lanes, exp_lanes(c));
        end

        tag = "R8";
        set_mode(2'd1);
        ev(0, 8'h41, 8'hEE);
        check("R8 snoop ignored in mode1", ffe_level, 8'h00);
        ev(1, 8'h41, 8'hEE);
        ev(1, 8'h42, 8'h0E);
        check("R8 host used in mode1", ffe_level, 8'h15);

        tag = "R9";
        @(posedge clk); #1 ovr_ffe = 8'hB4; mode = 2'd2; @(negedge clk);
        check("R9 override", ffe_level, 8'hB4);
        ev(1, 8'h41, 8'hEE);
        check("R9 override holds", ffe_level, 8'hB4);
        set_mode(2'd3);
        check("R9 mode3 override", ffe_level, 8'hB4);
        set_mode(2'd1);
        check("R9 tracked kept", ffe_level, 8'h1A);

        tag = "R10";
        ev(1, 8'h35, 8'h08);
        check("R10 no_ffe zeroes", ffe_level, 8'h00);
        check("R10 bits", {no_ffe, deemph_only, preshoot_only}, 3'b100);
        ev(1, 8'h35, 8'h06);
        check("R10 bits2", {no_ffe, deemph_only, preshoot_only}, 3'b011);
        check("R10 levels kept", ffe_level, 8'h1A);

        tag = "R12";
        ev(1, 8'h20, 8'h02);
        check("R12 tmds set", tmds_ratio, 1);
        ev(1, 8'h20, 8'h01);
        check("R12 tmds clr", tmds_ratio, 0);

        tag = "R4";
        ev(1, 8'h31, 8'h30);
        ev(1, 8'h41, 8'h0E);
        ev(1, 8'h42, 8'hEF);
        check("R4 Fh beats Eh", ffe_level, 8'h00);

        tag = "R11";
        ev(1, 8'h31, 8'h36);
        ev(1, 8'h41, 8'hEE);
        ev(1, 8'h35, 8'h04);
        ev(1, 8'h20, 8'h02);
        ev(1, 8'h41, 8'hEE, 1);
        check("R11 levels", ffe_level, 8'h00);
        check("R11 rate", {frl_gbps, frl_lanes}, 0);
        check("R11 test/tmds", {no_ffe, deemph_only, preshoot_only, tmds_ratio}, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule